// File: doc/BRIEF.md
# Word-Aligned Instruction Fetch Sequencer

This block keeps the program counter of a single-issue core and chooses, once per clock, where the next instruction comes from: the following word, a relative branch destination, or an absolute jump destination. Since every instruction is a 32-bit word on a 4-byte boundary, only the upper 30 bits of the address are stored. The byte address presented to the instruction store is those 30 bits followed by two zero bits.

A small read-only instruction store is part of the block. Its words are computed at elaboration time from their index, and its read is combinational, so the fetched word matches the current address within the same cycle. The branch offset and the jump target are taken from that fetched word. The core's decoder supplies three plain control bits each cycle: a branch flag, the ALU equality result and a jump flag. None of these pins uses a handshake and there is no back-pressure. The fetch address advances on every clock edge that is not in reset.

The parameter `FAST_NPC` selects how the next address is added. With 1, two adders run in parallel and a multiplexer picks one result. With 0, a single adder takes a carry-in of one and a second operand that is either zero or the offset. Both settings must produce the same address sequence.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the address becomes 0 on that edge, so `iaddr_o` reads 0x00000000 and `instr_o` reads store word 0 after the edge.
- R2: `iaddr_o[1:0]` is always 00. `instr_o` is store word k, where k is `iaddr_o[7:2]` and word k = (k × 0x9E3779B9) XOR 0xA5F0FFFE, taken modulo 2^32.
- R3: When `jump_i` is 0 and `branch_i` AND `zero_i` is 0, the next byte address is the current one plus 4.
- R4: When `jump_i` is 0 and both `branch_i` and `zero_i` are 1, the next byte address is the current one plus 4 plus 4 × the sign-extended value of `instr_o[15:0]`.
- R5: A branch that has only one of `branch_i` and `zero_i` high takes the sequential path of R3.
- R6: When `jump_i` is 1, the next byte address is {current `iaddr_o[31:28]`, `instr_o[25:0]`, 2'b00}.
- R7: `jump_i` takes priority over a taken branch. With all three controls high, R6 applies.
- R8: Address arithmetic wraps modulo 2^32 on the byte address. Stepping from 0xFFFFFFFC gives 0, and a backward branch from 0 can land at 0xFFFFFFFC. No other effect occurs.
- R9: Both settings of `FAST_NPC` produce identical `iaddr_o` sequences for identical input sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| branch_i | input | 1 | Current instruction is a conditional branch |
| zero_i | input | 1 | ALU equality result for the branch |
| jump_i | input | 1 | Current instruction is an absolute jump |
| iaddr_o | output | 32 | Byte fetch address, word aligned |
| instr_o | output | 32 | Instruction word at `iaddr_o` |

## Verification
The hardest states to reach are the two wrap boundaries of the 30-bit word counter. From the ports they can only be reached through a branch whose offset comes out of the store. Store word 0 is built to carry the offset 0xFFFE, so a taken branch right after reset lands on the last word. One plain step from there must then give address 0. Random control patterns drive the rest. Their branches and jumps scatter the upper address bits, which exercises the splice of the four kept bits. Two instances, one for each adder variant, run side by side against one model.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned WPC_W   = 30;
  localparam int unsigned TGT_W   = 26;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned HI_W    = WPC_W - TGT_W;

  typedef enum logic [1:0] {
    NSEL_SEQ = 2'd0,
    NSEL_BR  = 2'd1,
    NSEL_JMP = 2'd2
  } nsel_e;

  function automatic logic [INSTR_W-1:0] store_word(input int unsigned k);
    logic [INSTR_W-1:0] prod;
    prod = INSTR_W'(k) * 32'h9E3779B9;
    return prod ^ 32'hA5F0FFFE;
  endfunction

  function automatic logic [WPC_W-1:0] sext_off(input logic [IMM_W-1:0] imm);
    return {{(WPC_W-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction
endpackage

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int unsigned W = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pc_d,
  output logic [W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end
endmodule

// File: rtl/fetch_imem.sv
module fetch_imem #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32
) (
  input  logic [AW-1:0] idx,
  output logic [DW-1:0] word
);
  import fetch_pkg::*;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom[g] = DW'(store_word(g));
  end

  assign word = rom[idx];
endmodule

// File: rtl/fetch_npc_add.sv
module fetch_npc_add #(
  parameter int unsigned W    = 30,
  parameter bit          FAST = 1'b1
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] off,
  input  logic         take,
  output logic [W-1:0] npc
);
  if (FAST) begin : g_fast
    logic [W-1:0] inc_v;
    logic [W-1:0] br_v;
    assign inc_v = pc + W'(1);
    assign br_v  = pc + off + W'(1);
    assign npc   = take ? br_v : inc_v;
  end else begin : g_cheap
    logic [W-1:0] opnd;
    logic         cin;
    assign opnd = take ? off : '0;
    assign cin  = 1'b1;
    assign npc  = pc + opnd + W'(cin);
  end
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit #(
  parameter bit          FAST_NPC = 1'b1,
  parameter int unsigned IMEM_AW  = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        branch_i,
  input  logic        zero_i,
  input  logic        jump_i,
  output logic [31:0] iaddr_o,
  output logic [31:0] instr_o
);
  import fetch_pkg::*;

  logic [WPC_W-1:0]   wpc;
  logic [WPC_W-1:0]   wpc_nxt;
  logic [WPC_W-1:0]   add_res;
  logic [WPC_W-1:0]   jmp_res;
  logic [WPC_W-1:0]   off;
  logic [INSTR_W-1:0] iw;
  logic               br_take;
  nsel_e              sel;

  fetch_pc_reg #(.W(WPC_W)) u_pc (
    .clk (clk),
    .rst (rst),
    .pc_d(wpc_nxt),
    .pc_q(wpc)
  );

  fetch_imem #(.AW(IMEM_AW), .DW(INSTR_W)) u_mem (
    .idx (wpc[IMEM_AW-1:0]),
    .word(iw)
  );

  assign off     = sext_off(iw[IMM_W-1:0]);
  assign br_take = branch_i & zero_i;

  fetch_npc_add #(.W(WPC_W), .FAST(FAST_NPC)) u_add (
    .pc  (wpc),
    .off (off),
    .take(br_take),
    .npc (add_res)
  );

  assign jmp_res = {wpc[WPC_W-1 -: HI_W], iw[TGT_W-1:0]};

  always_comb begin
    if (jump_i)       sel = NSEL_JMP;
    else if (br_take) sel = NSEL_BR;
    else              sel = NSEL_SEQ;
  end

  always_comb begin
    unique case (sel)
      NSEL_JMP: wpc_nxt = jmp_res;
      default:  wpc_nxt = add_res;
    endcase
  end

  assign iaddr_o = {wpc, 2'b00};
  assign instr_o = iw;

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!jump_i && !(branch_i && zero_i)) |=> (iaddr_o == $past(iaddr_o) + 32'd4));

  // R4
  br_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!jump_i && branch_i && zero_i) |=>
      (iaddr_o == $past(iaddr_o) + 32'd4 + {{14{$past(instr_o[15])}}, $past(instr_o[15:0]), 2'b00}));

  // R6
  jump_dst_chk: assert property (@(posedge clk) disable iff (rst)
    jump_i |=> (iaddr_o == {$past(iaddr_o[31:28]), $past(instr_o[25:0]), 2'b00}));

  // R7
  jump_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (jump_i && branch_i && zero_i) |=> (iaddr_o[27:2] == $past(instr_o[25:0])));

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!jump_i && !branch_i && iaddr_o == 32'hFFFFFFFC) |=> (iaddr_o == 32'd0));
endmodule

// File: tb/sim_fetch_unit.sv
module sim_fetch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br = 1'b0, zr = 1'b0, jp = 1'b0;
  logic [31:0] a0, i0, a1, i1;
  logic [29:0] mpc;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fetch_unit #(.FAST_NPC(1'b1)) u0 (.clk(clk), .rst(rst), .branch_i(br), .zero_i(zr),
    .jump_i(jp), .iaddr_o(a0), .instr_o(i0));
  fetch_unit #(.FAST_NPC(1'b0)) u1 (.clk(clk), .rst(rst), .branch_i(br), .zero_i(zr),
    .jump_i(jp), .iaddr_o(a1), .instr_o(i1));

  function automatic logic [31:0] word_at(input logic [29:0] w);
    logic [31:0] k;
    k = {26'd0, w[5:0]};
    return (k * 32'h9E3779B9) ^ 32'hA5F0FFFE;
  endfunction

  function automatic logic [29:0] next_of(input logic [29:0] w, input logic b,
                                          input logic z, input logic j);
    logic [31:0] iw;
    iw = word_at(w);
    if (j)           return {w[29:26], iw[25:0]};
    else if (b && z) return w + 30'd1 + {{14{iw[15]}}, iw[15:0]};
    else             return w + 30'd1;
  endfunction

  task automatic check(input string tag);
    logic [31:0] ea, ei;
    ea = {mpc, 2'b00};
    ei = word_at(mpc);
    total++;
    if (a0 !== ea || i0 !== ei) begin
      bad++;
      $display("FAIL %s fast: addr=%h instr=%h expected addr=%h instr=%h", tag, a0, i0, ea, ei);
    end
    total++;
    if (a1 !== ea || i1 !== ei || a1 !== a0) begin
      bad++;
      $display("FAIL %s R9 cheap: addr=%h instr=%h expected addr=%h instr=%h", tag, a1, i1, ea, ei);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs checked
  task automatic step(input logic b, input logic z, input logic j, input string tag);
    br = b; zr = z; jp = j;
    mpc = next_of(mpc, b, z, j);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; br = 1'b0; zr = 1'b0; jp = 1'b0;
    @(posedge clk);
    @(negedge clk);
    mpc = '0;
    check("R1 reset");
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    mpc = '0;
    r = $urandom(32'd2024);
    @(negedge clk);
    do_reset();
    check("R2 word0");
    // R8 backward branch from 0 to last word, then wrap forward
    step(1'b1, 1'b1, 1'b0, "R4 R8 back");
    step(1'b0, 1'b0, 1'b0, "R8 wrap");
    step(1'b0, 1'b0, 1'b0, "R3 seq");
    step(1'b1, 1'b0, 1'b0, "R5 br_only");
    step(1'b0, 1'b1, 1'b0, "R5 zero_only");
    step(1'b1, 1'b1, 1'b0, "R4 taken");
    step(1'b1, 1'b1, 1'b0, "R4 taken2");
    step(1'b0, 1'b0, 1'b1, "R6 jump");
    step(1'b1, 1'b1, 1'b1, "R7 prio");
    step(1'b0, 1'b1, 1'b1, "R7 prio2");
    // mid-run reset
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic b, z, j;
      string tag;
      r = $urandom;
      b = r[0]; z = r[1]; j = (r[4:2] == 3'd0);
      if (j)          tag = (b && z) ? "R7 rnd" : "R6 rnd";
      else if (b && z) tag = "R4 rnd";
      else if (b || z) tag = "R5 rnd";
      else            tag = "R3 rnd";
      step(b, z, j, tag);
      if (a0[1:0] != 2'b00) begin
        bad++;
        $display("FAIL R2 align: addr=%h expected low bits 00", a0);
      end
      total++;
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule